// File: doc/BRIEF.md
# Stand-alone Trigger and Fast-Command Generator

This block produces the four fast commands of a front-end test setup: a level-1 trigger accept, an event-counter reset, a bunch-counter reset and a calibrate strobe. All four are aligned to the bunch-crossing clock. It lets a test stand run without the central timing system. Software can ask for one trigger at any time, or start a repetitive run. A run either fires at a fixed programmed spacing or draws triggers pseudo-randomly at a programmed mean rate. A programmed count can end the run by itself, or it can run until it is told to stop. Software can also request the three other commands at any time.

Each output is a one-clock pulse, and at most one command leaves per clock. Requests that collide are held and released in a fixed order of precedence. While the downstream busy line is high, no trigger is issued and none is counted. Raising the external-mode select discards all local activity. The block then forwards externally supplied commands with one register of delay.

Top module: `trig_pattern_gen`

## Requirements
- R1: After reset all four command outputs and `running` are low.
- R2: A `single_req` sampled at a clock edge produces an `l1a` pulse of one clock, visible after that same edge, when no higher-precedence command is waiting and `busy` is low.
- R3: With `cfg_random` = 0 and `cfg_period` = P (P >= 1), the first `l1a` appears P clocks after the edge that samples `start`, and a further one every P clocks after that.
- R4: With `cfg_count` = N > 0, a run stops by itself (`running` low) at the edge that issues its N-th trigger. With N = 0 it runs until `stop`, after which no further run trigger is issued.
- R5: With `cfg_random` = 1, a trigger is drawn on each clock where a free-running 32-bit maximal-length LFSR is below `cfg_threshold`. A threshold of 0 yields no triggers, and the mean rate is threshold / 2^32.
- R6: At most one command output is high per clock. The precedence is bcr, then ecr, then l1a, then cal. A command that loses is held and issued on the next clock that no higher command claims.
- R7: While `busy` is high, no locally generated trigger (single or run) is issued, and run triggers lost this way do not count toward N.
- R8: With `ext_mode` = 1, each output equals its `ext_*` input delayed by one clock. Local requests are discarded, waiting commands are dropped and `running` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_random | input | 1 | Run type: 0 fixed spacing, 1 pseudo-random |
| cfg_period | input | PER_W | Fixed spacing in clocks (0 acts as 1) |
| cfg_threshold | input | 32 | Random draw threshold |
| cfg_count | input | CNT_W | Triggers per run, 0 = unlimited |
| ext_mode | input | 1 | Forward external commands |
| start | input | 1 | Start (or restart) a run |
| stop | input | 1 | End a run |
| single_req | input | 1 | Request one trigger |
| ecr_req | input | 1 | Request event-counter reset |
| bcr_req | input | 1 | Request bunch-counter reset |
| cal_req | input | 1 | Request calibrate |
| busy | input | 1 | Masked busy, blocks triggers |
| ext_l1a | input | 1 | External trigger |
| ext_ecr | input | 1 | External event-counter reset |
| ext_bcr | input | 1 | External bunch-counter reset |
| ext_cal | input | 1 | External calibrate |
| l1a | output | 1 | Trigger accept pulse |
| ecr | output | 1 | Event-counter reset pulse |
| bcr | output | 1 | Bunch-counter reset pulse |
| cal | output | 1 | Calibrate pulse |
| running | output | 1 | A run is active |

## Verification
The bench goes after the period phase, including P = 1. If the counter were off by one, every trigger would be a clock early or late. It sends all four requests in the same clock and then random mixes against a reference queue. A priority or hold error shows up there as two pulses in one clock, a lost command or a wrong order. Busy is held over the first trigger slots of a counted run, so counting suppressed triggers would end the run short. Random runs with a zero threshold and a one-quarter threshold catch a wrong comparison direction. External mode is driven with requests active on the local side, which exposes any local command that leaks through.

// File: rtl/trig_pattern_gen.sv
module trig_pattern_gen #(
  parameter int PER_W = 16,
  parameter int CNT_W = 16,
  parameter logic [31:0] LFSR_SEED = 32'h0000_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_random,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [31:0]      cfg_threshold,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             ext_mode,
  input  logic             start,
  input  logic             stop,
  input  logic             single_req,
  input  logic             ecr_req,
  input  logic             bcr_req,
  input  logic             cal_req,
  input  logic             busy,
  input  logic             ext_l1a,
  input  logic             ext_ecr,
  input  logic             ext_bcr,
  input  logic             ext_cal,
  output logic             l1a,
  output logic             ecr,
  output logic             bcr,
  output logic             cal,
  output logic             running
);

  logic [31:0]      lfsr;
  logic [PER_W-1:0] per_cnt;
  logic [CNT_W-1:0] gen_cnt;
  logic             hold_l1a, hold_ecr, hold_bcr, hold_cal;

  wire [PER_W-1:0] reload = (cfg_period == '0) ? '0 : cfg_period - 1'b1;
  wire lfsr_fb = lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0];

  wire fire    = running & (cfg_random ? (lfsr < cfg_threshold) : (per_cnt == '0));
  wire accept  = fire & ~busy;
  wire last    = accept && (cfg_count != '0) && (gen_cnt == cfg_count - 1'b1);
  wire new_l1a = (single_req | fire) & ~busy;

  wire av_bcr = hold_bcr | bcr_req;
  wire av_ecr = hold_ecr | ecr_req;
  wire av_l1a = hold_l1a | new_l1a;
  wire av_cal = hold_cal | cal_req;

  wire g_bcr = av_bcr;
  wire g_ecr = av_ecr & ~av_bcr;
  wire g_l1a = av_l1a & ~av_bcr & ~av_ecr;
  wire g_cal = av_cal & ~av_bcr & ~av_ecr & ~av_l1a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr    <= LFSR_SEED;
      per_cnt <= '0;
      gen_cnt <= '0;
      running <= 1'b0;
      {l1a, ecr, bcr, cal} <= '0;
      {hold_l1a, hold_ecr, hold_bcr, hold_cal} <= '0;
    end else begin
      lfsr <= {lfsr[30:0], lfsr_fb};
      if (ext_mode) begin
        {l1a, ecr, bcr, cal} <= {ext_l1a, ext_ecr, ext_bcr, ext_cal};
        {hold_l1a, hold_ecr, hold_bcr, hold_cal} <= '0;
        running <= 1'b0;
        gen_cnt <= '0;
      end else begin
        {l1a, ecr, bcr, cal} <= {g_l1a, g_ecr, g_bcr, g_cal};
        hold_bcr <= av_bcr & ~g_bcr;
        hold_ecr <= av_ecr & ~g_ecr;
        hold_l1a <= av_l1a & ~g_l1a;
        hold_cal <= av_cal & ~g_cal;
        if (start) begin
          running <= 1'b1;
          per_cnt <= reload;
          gen_cnt <= '0;
        end else if (stop || last) begin
          running <= 1'b0;
        end else if (running) begin
          per_cnt <= (per_cnt == '0) ? reload : per_cnt - 1'b1;
          gen_cnt <= gen_cnt + CNT_W'(accept);
        end
      end
    end
  end

  p_one_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ext_mode) |-> $onehot0({l1a, ecr, bcr, cal}));

  p_bcr_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bcr_req && !ext_mode) |=> bcr);

  p_busy_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ext_mode && !hold_l1a) |=> !l1a);

  p_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !running);

  p_ext_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |=> (l1a == $past(ext_l1a)) && (cal == $past(ext_cal)) && !running);

  p_zero_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cfg_random && cfg_threshold == '0) |-> !fire);

endmodule

// File: tb/test_trig_pattern_gen.sv
`timescale 1ns/1ps
module test_trig_pattern_gen;
  logic clk = 0, rst_n = 0;
  logic cfg_random = 0;
  logic [15:0] cfg_period = 16'd1, cfg_count = 16'd0;
  logic [31:0] cfg_threshold = 0;
  logic ext_mode = 0, start = 0, stop = 0, single_req = 0, ecr_req = 0, bcr_req = 0, cal_req = 0, busy = 0;
  logic ext_l1a = 0, ext_ecr = 0, ext_bcr = 0, ext_cal = 0;
  logic l1a, ecr, bcr, cal, running;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  trig_pattern_gen i_trig_pattern_gen (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pick(logic [3:0] av); // {bcr,ecr,l1a,cal}
    if (av[3]) return 4'b1000;
    if (av[2]) return 4'b0100;
    if (av[1]) return 4'b0010;
    if (av[0]) return 4'b0001;
    return 4'b0000;
  endfunction

  task automatic end_run();
    stop = 1; tick(); stop = 0; tick(); tick();
    chk("R4 stopped", running, 0);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int seen;
    logic [3:0] hold, av, g;
    void'($urandom(32'd2024));
    tick(); tick(); rst_n = 1; tick();
    chk("R1 outputs", {l1a, ecr, bcr, cal}, 0);
    chk("R1 running", running, 0);

    // R2 single trigger
    single_req = 1; tick(); single_req = 0;
    chk("R2 pulse", {bcr, ecr, l1a, cal}, 4'b0010);
    tick();
    chk("R2 one clock", l1a, 0);

    // R6 collision of all four
    bcr_req = 1; ecr_req = 1; single_req = 1; cal_req = 1; tick();
    bcr_req = 0; ecr_req = 0; single_req = 0; cal_req = 0;
    chk("R6 bcr first", {bcr, ecr, l1a, cal}, 4'b1000); tick();
    chk("R6 ecr second", {bcr, ecr, l1a, cal}, 4'b0100); tick();
    chk("R6 l1a third", {bcr, ecr, l1a, cal}, 4'b0010); tick();
    chk("R6 cal fourth", {bcr, ecr, l1a, cal}, 4'b0001); tick();
    chk("R6 drained", {bcr, ecr, l1a, cal}, 4'b0000);

    // R3 fixed spacing, P=1 then random P
    for (int t = 0; t < 4; t++) begin
      int p = (t == 0) ? 1 : 1 + int'($urandom_range(19));
      cfg_random = 0; cfg_period = 16'(p); cfg_count = 0;
      start = 1; tick(); start = 0;
      for (int i = 1; i <= 4 * p; i++) begin
        tick();
        chk("R3 phase", l1a, (i % p == 0) ? 1 : 0);
      end
      end_run();
      tick();
      chk("R4 no trigger after stop", l1a, 0);
    end

    // R4 counted burst
    for (int t = 0; t < 3; t++) begin
      int n = 1 + int'($urandom_range(5));
      int p = 2 + int'($urandom_range(3));
      cfg_period = 16'(p); cfg_count = 16'(n); seen = 0;
      start = 1; tick(); start = 0;
      for (int i = 1; i <= (n + 3) * p; i++) begin
        tick(); seen += int'(l1a);
      end
      chk("R4 burst total", seen, n);
      chk("R4 burst self stop", running, 0);
    end

    // R7 busy masks and is not counted
    cfg_period = 3; cfg_count = 4; seen = 0;
    start = 1; tick(); start = 0;
    for (int i = 1; i <= 24; i++) begin
      busy = (i <= 6); tick(); seen += int'(l1a);
      if (i <= 6) chk("R7 suppressed", l1a, 0);
    end
    busy = 0;
    chk("R7 total after busy", seen, 4);
    chk("R7 run ended", running, 0);

    // R5 random
    cfg_random = 1; cfg_count = 0; cfg_threshold = 0; seen = 0;
    start = 1; tick(); start = 0;
    for (int i = 0; i < 500; i++) begin tick(); seen += int'(l1a); end
    chk("R5 zero threshold", seen, 0);
    cfg_threshold = 32'h4000_0000; seen = 0;
    for (int i = 0; i < 4000; i++) begin tick(); seen += int'(l1a); end
    chk("R5 mean rate", (seen > 700 && seen < 1300) ? 1 : 0, 1);
    end_run();
    cfg_threshold = 32'h8000_0000; cfg_count = 5; seen = 0;
    start = 1; tick(); start = 0;
    for (int i = 0; i < 300; i++) begin tick(); seen += int'(l1a); end
    chk("R5 random burst count", seen, 5);
    chk("R5 random burst stopped", running, 0);
    cfg_random = 0; cfg_count = 0;

    // R6/R7 random request mixes against a reference queue
    hold = 0;
    for (int i = 0; i < 400; i++) begin
      bcr_req = ($urandom_range(9) == 0);
      ecr_req = ($urandom_range(6) == 0);
      single_req = ($urandom_range(4) == 0);
      cal_req = ($urandom_range(4) == 0);
      busy = ($urandom_range(3) == 0);
      av = hold | {bcr_req, ecr_req, single_req & ~busy, cal_req};
      g = pick(av);
      hold = av & ~g;
      tick();
      chk("R6 random mix", {bcr, ecr, l1a, cal}, g);
    end
    {bcr_req, ecr_req, single_req, cal_req, busy} = 0;
    for (int i = 0; i < 6; i++) tick();

    // R8 external pass-through
    cfg_period = 2; start = 1; tick(); start = 0;
    ext_mode = 1;
    for (int i = 0; i < 60; i++) begin
      logic [3:0] v = 4'($urandom);
      {ext_l1a, ext_ecr, ext_bcr, ext_cal} = v;
      {single_req, bcr_req, ecr_req, cal_req} = 4'($urandom);
      start = ($urandom_range(3) == 0);
      tick();
      chk("R8 forward", {l1a, ecr, bcr, cal}, v);
      chk("R8 no run", running, 0);
    end
    {ext_l1a, ext_ecr, ext_bcr, ext_cal} = 0;
    {single_req, bcr_req, ecr_req, cal_req, start} = 0;
    ext_mode = 0; tick(); tick();
    chk("R8 locals discarded", {l1a, ecr, bcr, cal}, 0);
    chk("R8 running cleared", running, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule